// File: doc/BRIEF.md
# Lane-Partitioned SIMD Integer ALU

This block is the integer execution unit of a small virtual-processor core. It treats a 64-bit register as a row of equal lanes and applies one operation to every lane at once. A 2-bit width code picks the lane size: eight bytes, four 16-bit words, two 32-bit longs or one 64-bit double. Each lane is computed on its own. No carry, borrow or shifted bit crosses from one lane into the next.

The operations are subtract, signed multiply that keeps the low lane bits, arithmetic shift left, arithmetic shift right, and bitwise OR, AND and XOR. OR with a zero second operand serves as a register move. When the accumulate input is high, each lane result is added to the matching lane of the current destination value instead of replacing it. A result is registered one cycle after its input strobe and is flagged by an output strobe.

Top module: `simd_int_alu`

## Requirements
- R1: `width_sel` selects the lane size: 00 gives 8-bit lanes, 01 gives 16-bit, 10 gives 32-bit and 11 gives 64-bit. Lane i occupies bits [i*w +: w]. Every lane is computed independently, so no carry or borrow crosses a lane boundary.
- R2: `op_sel` 000 (subtract) gives, in each lane, a - b modulo 2^w.
- R3: `op_sel` 001 (multiply) gives, in each lane, the low w bits of the signed product a*b. Overflow is discarded.
- R4: `op_sel` 010 (shift left) shifts each a lane left by (b lane mod w) and fills the vacated bits with zeros.
- R5: `op_sel` 011 (arithmetic shift right) shifts each a lane right by (b lane mod w) and fills the vacated bits with that lane's own sign bit.
- R6: `op_sel` 100, 101 and 110 give a OR b, a AND b and a XOR b. OR with b equal to zero returns a unchanged.
- R7: `op_sel` 111 is unassigned and gives a lane result of zero.
- R8: When `acc_en` is 1, each output lane is (`acc_dst` lane + lane result) modulo 2^w. When it is 0, the output lane is the lane result alone.
- R9: `out_data` and `out_valid` update on the clock edge that samples `in_valid` high, which is a latency of one cycle. When `in_valid` is low, `out_valid` goes low and `out_data` holds its value. Reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | First operand register |
| op_b | input | 64 | Second operand register (also the per-lane shift amount) |
| op_sel | input | 3 | Operation code |
| width_sel | input | 2 | Lane width code |
| acc_en | input | 1 | Add the lane result into the destination lanes |
| acc_dst | input | 64 | Current destination value used when accumulating |
| out_valid | output | 1 | Registered result strobe |
| out_data | output | 64 | Registered 64-bit result |

## Verification
The bench aims at lane boundaries. A borrow out of the low byte must stay inside that byte, so a design that leaks it would corrupt byte 1 and show up as a wrong neighbour lane. Arithmetic right shift is driven with negative lanes sitting next to positive ones: a design that used the word sign, or that shifted logically, would fill the wrong bits. Shift amounts are swept over all 64 values to catch a design that does not reduce the amount modulo the lane width and so shifts everything out. Accumulation is run with destination lanes near overflow, which catches a sum that carries into the next lane. The hold-when-idle and move-by-OR cases would reveal a register that loads on every cycle or an OR that mixes in stale data.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int unsigned DATA_W = 64;

    typedef enum logic [2:0] {
        OP_SUB  = 3'b000,
        OP_MUL  = 3'b001,
        OP_SHL  = 3'b010,
        OP_SHR  = 3'b011,
        OP_OR   = 3'b100,
        OP_AND  = 3'b101,
        OP_XOR  = 3'b110,
        OP_NONE = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        W_BYTE   = 2'b00,
        W_WORD   = 2'b01,
        W_LONG   = 2'b10,
        W_DOUBLE = 2'b11
    } lane_w_e;

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_alu_pkg::*;
#(
    parameter int unsigned LW = 8
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic [LW-1:0] d,
    input  alu_op_e       op,
    input  logic          acc,
    output logic [LW-1:0] y
);
    localparam int unsigned SW = $clog2(LW);

    logic [SW-1:0] amt;
    logic [LW-1:0] prod;
    logic [LW-1:0] shl;
    logic [LW-1:0] shr;
    logic [LW-1:0] r;

    // shift amount taken modulo the lane width
    assign amt  = b[SW-1:0];
    // the low LW bits of a signed and an unsigned product are identical
    assign prod = a * b;
    assign shl  = a << amt;
    assign shr  = LW'($signed(a) >>> amt);

    always_comb begin
        unique case (op)
            OP_SUB:  r = a - b;
            OP_MUL:  r = prod;
            OP_SHL:  r = shl;
            OP_SHR:  r = shr;
            OP_OR:   r = a | b;
            OP_AND:  r = a & b;
            OP_XOR:  r = a ^ b;
            default: r = '0;
        endcase
    end

    assign y = acc ? (d + r) : r;

endmodule

// File: rtl/simd_lane_group.sv
module simd_lane_group
    import simd_alu_pkg::*;
#(
    parameter int unsigned DW = 64,
    parameter int unsigned LW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] d,
    input  alu_op_e       op,
    input  logic          acc,
    output logic [DW-1:0] y
);
    localparam int unsigned NL = DW / LW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        simd_lane_unit #(.LW(LW)) u_lane (
            .a   (a[i*LW +: LW]),
            .b   (b[i*LW +: LW]),
            .d   (d[i*LW +: LW]),
            .op  (op),
            .acc (acc),
            .y   (y[i*LW +: LW])
        );
    end

endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
    import simd_alu_pkg::*;
#(
    parameter int unsigned DW       = DATA_W,
    parameter int unsigned BASE_LW  = 8,
    parameter int unsigned N_WIDTHS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [63:0]   op_a,
    input  logic [63:0]   op_b,
    input  logic [2:0]    op_sel,
    input  logic [1:0]    width_sel,
    input  logic          acc_en,
    input  logic [63:0]   acc_dst,
    output logic          out_valid,
    output logic [63:0]   out_data
);
    alu_op_e        op;
    logic [DW-1:0]  grp_y [N_WIDTHS];
    logic [DW-1:0]  sel_y;

    assign op = alu_op_e'(op_sel);

    for (genvar k = 0; k < N_WIDTHS; k++) begin : g_width
        simd_lane_group #(.DW(DW), .LW(BASE_LW << k)) u_grp (
            .a   (op_a),
            .b   (op_b),
            .d   (acc_dst),
            .op  (op),
            .acc (acc_en),
            .y   (grp_y[k])
        );
    end

    always_comb begin
        unique case (lane_w_e'(width_sel))
            W_BYTE:   sel_y = grp_y[0];
            W_WORD:   sel_y = grp_y[1];
            W_LONG:   sel_y = grp_y[2];
            default:  sel_y = grp_y[3];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= sel_y;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data))); // R9
    AST_OR_ZERO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'b100 && op_b == '0 && !acc_en) |=> (out_data == $past(op_a))); // R6
    AST_SUB_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'b000 && op_a == op_b && !acc_en) |=> (out_data == '0)); // R2
    AST_SHR_LANE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'b011 && width_sel == 2'b00 && !acc_en)
        |=> ((out_data & 64'h8080_8080_8080_8080) == ($past(op_a) & 64'h8080_8080_8080_8080))); // R5

endmodule

// File: tb/simd_int_alu_tb.sv
`timescale 1ns/1ps
module simd_int_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0, acc_dst = '0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  width_sel = '0;
    logic        acc_en = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    simd_int_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .width_sel(width_sel),
        .acc_en(acc_en), .acc_dst(acc_dst),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    function automatic logic [63:0] corner(input int i);
        case (i % 8)
            0: return 64'h0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h8080_8080_8080_8080;
            3: return 64'h7F7F_7F7F_7F7F_7F7F;
            4: return 64'h0101_0101_0101_0101;
            5: return 64'h8000_0000_0000_0000;
            6: return 64'h0123_4567_89AB_CDEF;
            default: return 64'hFF00_FF00_00FF_00FF;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic acc);
        if (acc) return "R8";
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd7: return "R7";
            default: return "R6";
        endcase
    endfunction

    // Reference model computed lane by lane with plain 64-bit arithmetic.
    function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] w,
                                          input logic acc, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] d);
        int lw = 8 << w;
        int nl = 64 / lw;
        logic [63:0] mask = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
        logic [63:0] res = '0;
        for (int i = 0; i < nl; i++) begin
            logic [63:0] la = (a >> (i*lw)) & mask;
            logic [63:0] lb = (b >> (i*lw)) & mask;
            logic [63:0] ld = (d >> (i*lw)) & mask;
            logic signed [63:0] sa = $signed(la << (64 - lw)) >>> (64 - lw);
            logic signed [63:0] sb = $signed(lb << (64 - lw)) >>> (64 - lw);
            int sh = int'(lb % 64'(lw));
            logic [63:0] r;
            case (op)
                3'd0: r = la - lb;
                3'd1: r = 64'(sa * sb);
                3'd2: r = la << sh;
                3'd3: r = 64'(sa >>> sh);
                3'd4: r = la | lb;
                3'd5: r = la & lb;
                3'd6: r = la ^ lb;
                default: r = 64'd0;
            endcase
            if (acc) r = r + ld;
            res = res | ((r & mask) << (i*lw));
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation at a falling edge, sample the result one cycle later.
    task automatic run_vec(input string tag, input logic [2:0] op, input logic [1:0] w,
                           input logic acc, input logic [63:0] a, input logic [63:0] b,
                           input logic [63:0] d);
        in_valid = 1'b1; op_sel = op; width_sel = w; acc_en = acc;
        op_a = a; op_b = b; acc_dst = d;
        @(negedge clk);
        check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, out_data, model(op, w, acc, a, b, d));
    endtask

    initial begin
        #(8 * 150000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset valid", {63'd0, out_valid}, 64'd0);
        check("R9 reset data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: borrow stays inside its lane at each width
        run_vec("R1 byte", 3'd0, 2'd0, 1'b0, 64'h0, 64'h1, 64'h0);
        check("R1 byte lane", out_data, 64'h0000_0000_0000_00FF);
        run_vec("R1 word", 3'd0, 2'd1, 1'b0, 64'h0, 64'h1, 64'h0);
        check("R1 word lane", out_data, 64'h0000_0000_0000_FFFF);
        run_vec("R1 long", 3'd0, 2'd2, 1'b0, 64'h0, 64'h1, 64'h0);
        check("R1 long lane", out_data, 64'h0000_0000_FFFF_FFFF);
        run_vec("R1 double", 3'd0, 2'd3, 1'b0, 64'h0, 64'h1, 64'h0);
        check("R1 double lane", out_data, 64'hFFFF_FFFF_FFFF_FFFF);
        // R5: own lane sign at byte width
        run_vec("R5 mixed signs", 3'd3, 2'd0, 1'b0, 64'h80_7F_80_7F_80_7F_80_7F, 64'h07_07_07_07_07_07_07_07, 64'h0);
        check("R5 mixed signs value", out_data, 64'hFF_00_FF_00_FF_00_FF_00);
        // R6: OR with zero is a move
        run_vec("R6 move", 3'd4, 2'd3, 1'b0, 64'hDEAD_BEEF_0123_4567, 64'h0, 64'hFFFF);
        check("R6 move value", out_data, 64'hDEAD_BEEF_0123_4567);
        // R8: accumulate wraps inside the lane
        run_vec("R8 wrap", 3'd4, 2'd0, 1'b1, 64'h01, 64'h0, 64'h00_00_00_00_00_00_00_FF);
        check("R8 wrap value", out_data, 64'h0);

        // Sweep: every op, width and accumulate setting, corner and random operands
        for (int op = 0; op < 8; op++)
            for (int w = 0; w < 4; w++)
                for (int ac = 0; ac < 2; ac++)
                    for (int v = 0; v < 48; v++) begin
                        logic [63:0] a, b, d;
                        if (v < 16) begin
                            a = corner(v); b = corner(v / 2 + 3); d = corner(v + 5);
                        end else begin
                            rng = next_rand(rng); a = rng;
                            rng = next_rand(rng); b = rng;
                            rng = next_rand(rng); d = rng;
                        end
                        run_vec(tag_of(3'(op), 1'(ac)), 3'(op), 2'(w), 1'(ac), a, b, d);
                    end

        // R4 / R5: every shift amount at every width, amounts reduced modulo the lane width
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 64; s++) begin
                logic [63:0] bs = {8{8'(s)}};
                run_vec("R4", 3'd2, 2'(w), 1'b0, 64'hC3A5_817E_F00F_5A96, bs, 64'h0);
                run_vec("R5", 3'd3, 2'(w), 1'b0, 64'hC3A5_817E_F00F_5A96, bs, 64'h0);
            end

        // R9: idle cycles hold the result and drop the strobe
        begin
            logic [63:0] held;
            run_vec("R9 load", 3'd6, 2'd3, 1'b0, 64'h1234, 64'h00FF, 64'h0);
            held = out_data;
            in_valid = 1'b0; op_a = 64'hFFFF; op_b = 64'h5555; op_sel = 3'd1;
            @(negedge clk);
            check("R9 idle valid", {63'd0, out_valid}, 64'd0);
            check("R9 idle hold", out_data, held);
            @(negedge clk);
            check("R9 idle hold 2", out_data, held);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule